// File: doc/BRIEF.md
# Iterative Radix-4 Integer Divider

This block performs the four integer division operations of a 32-bit RISC-V core with the M extension: signed quotient, unsigned quotient, signed remainder and unsigned remainder. A request is given as a one-cycle `start` together with two operands and an operation code. The operands are captured, turned into magnitudes in a setup cycle, and then pushed through a shift-compare-subtract loop that retires two quotient bits on every clock. The signs are applied to the final magnitudes at the output.

The latency is fixed, so the pipeline's hazard logic waits for the `valid` pulse and needs no knowledge of the operands. Divide-by-zero and the signed overflow case take the same number of cycles. Their results come from a bypass path that is chosen at the output, not from the loop. The block has no output back-pressure. While `busy` is high it takes no new request, and a `start` in that window is dropped. The result is presented for exactly the one cycle in which `valid` is high, and the consumer must take it in that cycle.

Top module: `div_r4_unit`

## Requirements
- R1: `op` selects the operation: 2'b00 signed quotient, 2'b01 unsigned quotient, 2'b10 signed remainder, 2'b11 unsigned remainder. Bit 1 set selects the remainder and bit 0 set selects unsigned operands. An unsigned quotient is rounded down.
- R2: A signed quotient is truncated toward zero. It is negative exactly when the operand signs differ and the magnitude is non-zero.
- R3: A signed remainder has the sign of the dividend, and its magnitude is less than that of the divisor.
- R4: `valid` rises in the cycle after the 17th rising edge that follows the edge sampling an accepted `start`. That is one setup edge followed by 16 loop edges, for every operation and every operand value.
- R5: `valid` is high for exactly one cycle per accepted request. `busy` is high from the accepting edge until the edge that ends the `valid` cycle, and `valid` is only high while `busy` is high.
- R6: A `start` sampled while `busy` is high, including during the `valid` cycle, is ignored. It produces no extra `valid` and does not alter the pending result.
- R7: With a zero divisor, both quotient operations return all ones and both remainder operations return the dividend unchanged.
- R8: For the signed operations with dividend 32'h8000_0000 and divisor 32'hFFFF_FFFF, the quotient is 32'h8000_0000 and the remainder is zero.
- R9: After reset, and in every cycle where `valid` is low, `busy` and `valid` are low (while idle) and `result` is zero.
- R10: The operands and `op` are sampled only at the accepting edge. Changes on those inputs during a calculation have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only while `busy` is low |
| op | input | 2 | Operation code (see R1) |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | A request is in progress |
| valid | output | 1 | One-cycle pulse: `result` holds the answer |
| result | output | 32 | Quotient or remainder, zero when `valid` is low |

## Verification
The hardest cases to reach from the ports are the ones where an operation is busy while its inputs keep changing. This covers `start` held high through the whole calculation, including the `valid` cycle, and the operands and operation code being scrambled on every cycle after acceptance. The bench runs half of its requests in this noisy mode. The reference model captures the operands only at acceptance, so any leak of the later inputs into the loop, the sign fix or the special-case bypass shows up as a result mismatch or as a stray `valid`. Directed requests cover both special cases under all four codes, and random requests bias the divisor toward small, zero and all-ones values.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_DONE
  } div_state_e;

  function automatic logic op_signed(input logic [1:0] op);
    return ~op[0];
  endfunction

  function automatic logic op_wants_rem(input logic [1:0] op);
    return op[1];
  endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep import div_pkg::*; #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] num_mag,
  output logic [W-1:0] den_mag,
  output logic         flip_quo,
  output logic         flip_rem,
  output logic         den_zero,
  output logic         sgn_ovf
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic sgn;
  logic num_neg;
  logic den_neg;

  always_comb begin
    sgn      = op_signed(op);
    num_neg  = sgn & num[W-1];
    den_neg  = sgn & den[W-1];
    num_mag  = num_neg ? (~num + 1'b1) : num;
    den_mag  = den_neg ? (~den + 1'b1) : den;
    flip_quo = num_neg ^ den_neg;
    flip_rem = num_neg;
    den_zero = (den == '0);
    sgn_ovf  = sgn & (num == MOST_NEG) & (den == '1);
  end
endmodule

// File: rtl/div_step_chain.sv
module div_step_chain #(
  parameter int W     = 32,
  parameter int STEPS = 2
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] quo_in,
  input  logic [W-1:0] den,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] quo_out
);
  logic [STEPS:0][W-1:0] rem_s;
  logic [STEPS:0][W-1:0] quo_s;

  assign rem_s[0] = rem_in;
  assign quo_s[0] = quo_in;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    logic [W:0]   shifted;
    logic [W+1:0] trial;
    logic         fits;

    always_comb begin
      shifted = {rem_s[s], quo_s[s][W-1]};
      trial   = {1'b0, shifted} - {2'b00, den};
      fits    = ~trial[W+1];
    end

    assign rem_s[s+1] = fits ? trial[W-1:0] : shifted[W-1:0];
    assign quo_s[s+1] = {quo_s[s][W-2:0], fits};
  end

  assign rem_out = rem_s[STEPS];
  assign quo_out = quo_s[STEPS];
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix import div_pkg::*; #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         flip_quo,
  input  logic         flip_rem,
  input  logic         den_zero,
  input  logic         sgn_ovf,
  input  logic [W-1:0] num_raw,
  output logic [W-1:0] res
);
  logic [W-1:0] quo_fin;
  logic [W-1:0] rem_fin;

  always_comb begin
    quo_fin = flip_quo ? (~quo_mag + 1'b1) : quo_mag;
    rem_fin = flip_rem ? (~rem_mag + 1'b1) : rem_mag;
    if (den_zero) begin
      res = op_wants_rem(op) ? num_raw : '1;
    end else if (sgn_ovf) begin
      res = op_wants_rem(op) ? '0 : num_raw;
    end else begin
      res = op_wants_rem(op) ? rem_fin : quo_fin;
    end
  end
endmodule

// File: rtl/div_r4_unit.sv
module div_r4_unit import div_pkg::*; #(
  parameter int WIDTH = 32,
  parameter int STEPS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             valid,
  output logic [WIDTH-1:0] result
);
  localparam int ITER = WIDTH / STEPS;
  localparam int CW   = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  div_state_e       state_q;
  logic [1:0]       op_q;
  logic [WIDTH-1:0] num_q;
  logic [WIDTH-1:0] den_raw_q;
  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] quo_q;
  logic [WIDTH-1:0] den_q;
  logic             flip_quo_q;
  logic             flip_rem_q;
  logic             den_zero_q;
  logic             sgn_ovf_q;
  logic [CW-1:0]    cnt_q;

  logic [WIDTH-1:0] num_mag;
  logic [WIDTH-1:0] den_mag;
  logic             flip_quo;
  logic             flip_rem;
  logic             den_zero;
  logic             sgn_ovf;
  logic [WIDTH-1:0] rem_nxt;
  logic [WIDTH-1:0] quo_nxt;
  logic [WIDTH-1:0] fixed;

  div_operand_prep #(.W(WIDTH)) u_prep (
    .op       (op_q),
    .num      (num_q),
    .den      (den_raw_q),
    .num_mag  (num_mag),
    .den_mag  (den_mag),
    .flip_quo (flip_quo),
    .flip_rem (flip_rem),
    .den_zero (den_zero),
    .sgn_ovf  (sgn_ovf)
  );

  div_step_chain #(.W(WIDTH), .STEPS(STEPS)) u_chain (
    .rem_in  (rem_q),
    .quo_in  (quo_q),
    .den     (den_q),
    .rem_out (rem_nxt),
    .quo_out (quo_nxt)
  );

  div_result_fix #(.W(WIDTH)) u_fix (
    .op       (op_q),
    .quo_mag  (quo_q),
    .rem_mag  (rem_q),
    .flip_quo (flip_quo_q),
    .flip_rem (flip_rem_q),
    .den_zero (den_zero_q),
    .sgn_ovf  (sgn_ovf_q),
    .num_raw  (num_q),
    .res      (fixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= '0;
      num_q      <= '0;
      den_raw_q  <= '0;
      rem_q      <= '0;
      quo_q      <= '0;
      den_q      <= '0;
      flip_quo_q <= 1'b0;
      flip_rem_q <= 1'b0;
      den_zero_q <= 1'b0;
      sgn_ovf_q  <= 1'b0;
      cnt_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q      <= op;
            num_q     <= dividend;
            den_raw_q <= divisor;
            state_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          rem_q      <= '0;
          quo_q      <= num_mag;
          den_q      <= den_mag;
          flip_quo_q <= flip_quo;
          flip_rem_q <= flip_rem;
          den_zero_q <= den_zero;
          sgn_ovf_q  <= sgn_ovf;
          cnt_q      <= '0;
          state_q    <= ST_RUN;
        end
        ST_RUN: begin
          rem_q <= rem_nxt;
          quo_q <= quo_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_DONE;
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign valid  = (state_q == ST_DONE);
  assign result = valid ? fixed : '0;
endmodule

// File: rtl/div_r4_checks.sv
module div_r4_checks #(
  parameter int W   = 32,
  parameter int LAT = 17
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         valid,
  input logic [W-1:0] result
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [15:0]  edges;
  logic [1:0]   cap_op;
  logic [W-1:0] cap_a;
  logic [W-1:0] cap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges  <= '0;
      cap_op <= '0;
      cap_a  <= '0;
      cap_b  <= '0;
    end else if (start && !busy) begin
      edges  <= '0;
      cap_op <= op;
      cap_a  <= dividend;
      cap_b  <= divisor;
    end else if (busy) begin
      edges <= edges + 1'b1;
    end
  end

  // R4: fixed latency from the accepting edge
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (edges == 16'(LAT)));

  // R5: single-cycle pulse, then idle
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (!valid && !busy));

  // R5: acceptance raises busy without an immediate result
  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !valid));

  // R5: no result outside a request
  p_valid_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy);

  // R7: zero divisor bypass, against operands captured at acceptance (R6, R10)
  p_divzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cap_b == '0) |-> (result == (cap_op[1] ? cap_a : '1)));

  // R8: signed overflow bypass
  p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !cap_op[0] && cap_a == MOST_NEG && cap_b == '1)
      |-> (result == (cap_op[1] ? '0 : cap_a)));
endmodule

bind div_r4_unit div_r4_checks #(.W(WIDTH), .LAT(WIDTH / STEPS + 1)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op       (op),
  .dividend (dividend),
  .divisor  (divisor),
  .busy     (busy),
  .valid    (valid),
  .result   (result)
);

// File: tb/div_r4_unit_bench.sv
`timescale 1ns/1ps
module div_r4_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opsel = 2'b00;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy;
  logic        valid;
  logic [31:0] result;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  bit    released = 1'b0;
  string test_tag = "-";

  // reference model state
  int          m_phase = 0;
  logic [31:0] m_exp = '0;
  string       m_tag = "";

  always #10 clk = ~clk;

  div_r4_unit u_div_r4_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (opsel),
    .dividend (dividend),
    .divisor  (divisor),
    .busy     (busy),
    .valid    (valid),
    .result   (result)
  );

  function automatic logic [31:0] ref_div(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
    int sa;
    int sb;
    if (b == 0) return op[1] ? a : 32'hFFFF_FFFF;       // R7
    if (!op[0]) begin
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF)
        return op[1] ? 32'h0 : a;                       // R8
      sa = a;
      sb = b;
      return op[1] ? 32'(sa % sb) : 32'(sa / sb);       // R2, R3
    end
    return op[1] ? (a % b) : (a / b);                   // R1
  endfunction

  function automatic string ref_tag(input logic [1:0] op, input logic [31:0] a,
                                    input logic [31:0] b);
    if (b == 0) return "R7";
    if (!op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R8";
    if (op == 2'b00) return "R2";
    if (op == 2'b10) return "R3";
    return "R1";
  endfunction

  // cycle model: 1 after accepting edge, 18 in the result cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0;
    end else if (m_phase == 18) begin
      m_phase <= 0;
    end else if (m_phase > 0) begin
      m_phase <= m_phase + 1;
    end else if (start) begin
      m_phase <= 1;
      m_exp   <= ref_div(opsel, dividend, divisor);
      m_tag   <= ref_tag(opsel, dividend, divisor);
    end
  end

  always @(negedge clk) begin
    logic        e_busy;
    logic        e_valid;
    logic [31:0] e_res;
    string       tag;
    if (!finished) begin
      e_busy  = (m_phase != 0);
      e_valid = (m_phase == 18);
      e_res   = e_valid ? m_exp : 32'h0;
      if (!released) tag = "R9";
      else if (e_valid) tag = m_tag;
      else tag = "R4 R5 R9";
      n_cmp++;
      if (busy !== e_busy || valid !== e_valid || result !== e_res) begin
        n_bad++;
        $display("FAIL %s (%s) t=%0t busy/valid/result actual %b/%b/%h expected %b/%b/%h",
                 tag, test_tag, $time, busy, valid, result, e_busy, e_valid, e_res);
      end
    end
  end

  // noisy: start held high and inputs scrambled while busy (R6, R10)
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                        input bit noisy);
    @(negedge clk);
    test_tag = noisy ? "R6 R10" : "-";
    dividend = a;
    divisor  = b;
    opsel    = op;
    start    = 1'b1;
    @(negedge clk);
    start = noisy;
    do begin
      if (noisy) begin
        dividend = $urandom;
        divisor  = $urandom;
        opsel    = 2'($urandom);
      end
      @(negedge clk);
    end while (m_phase != 0);
    start = 1'b0;
  endtask

  task automatic all_ops(input logic [31:0] a, input logic [31:0] b, input bit noisy);
    for (int k = 0; k < 4; k++) run_op(a, b, 2'(k), noisy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    released = 1'b1;

    // R1 R2 R3: sign combinations
    all_ops(32'd7, 32'd2, 1'b0);
    all_ops(-32'sd7, 32'd2, 1'b0);
    all_ops(32'd7, -32'sd2, 1'b0);
    all_ops(-32'sd7, -32'sd2, 1'b0);
    all_ops(-32'sd1, 32'd3, 1'b0);
    all_ops(32'hFFFF_FFFF, 32'd1, 1'b0);
    all_ops(32'd5, 32'hFFFF_FFFF, 1'b0);
    all_ops(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    all_ops(32'd0, 32'd9, 1'b0);
    // R7: zero divisor, quiet and noisy
    all_ops(32'h1234_5678, 32'd0, 1'b0);
    all_ops(32'h8000_0000, 32'd0, 1'b1);
    // R8: signed overflow and its neighbours
    all_ops(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    all_ops(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    all_ops(32'h8000_0000, 32'd1, 1'b0);
    all_ops(32'h8000_0001, 32'hFFFF_FFFF, 1'b0);
    // R6 R10: noisy directed
    all_ops(32'd1000, 32'd7, 1'b1);

    for (int i = 0; i < 160; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = $urandom;
      case ($urandom % 6)
        0: b = 32'($urandom % 17);
        1: b = 32'hFFFF_FFFF;
        2: b = -32'(($urandom % 9) + 1);
        3: b = 32'h0;
        default: b = $urandom >> ($urandom % 32);
      endcase
      run_op(a, b, 2'($urandom), bit'(i % 2));
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog (R4 R5) actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule